// File: doc/BRIEF.md
# Interleaved Memory Block-Fill Sequencer

This block refills one cache block from a banked main memory. A refill request carries a word address. The low offset bits of that address are dropped, so the fill always covers a whole aligned block of eight words. The sequencer places one word address per cycle on the address lane of a shared one-word memory bus. It sends each address to the bank that holds that word, and it counts each bank's fixed access time inside the block.

When a bank's word is ready, the sequencer opens a data phase on the bus. The memory returns that word, and the sequencer writes it into an on-chip staging buffer at its offset within the block. An address and a data word may use the bus in the same cycle. After the eighth word has been captured, the whole block is copied to the output register and a one-cycle completion strobe is raised. The consumer must not read the block before that strobe.

The number of banks is a parameter: 1, 4 or 8. The bank access time is also a parameter, 20 cycles by default. An address cycle, 20 access cycles and a one-cycle data transfer make 22 cycles per word when nothing overlaps. Requests that arrive while a fill is running are dropped.

Top module: `blkfill_seq`

## Requirements
- R1: After reset, mem_addr_vld, mem_data_vld and fill_done are low and fill_block is all zeros. While no fill is running, neither bus lane is active.
- R2: A request accepted at a clock edge puts the address of word offset 0 on mem_addr in the cycle that follows that edge. The block base is fill_addr with its low three bits forced to zero. Words are issued in ascending offset order, and the address of offset k is base+k.
- R3: A word's data phase comes exactly 21 cycles after the cycle in which its address was on the bus. mem_data_addr then shows that same word address.
- R4: Word offset k belongs to bank k mod NUM_BANKS. A bank takes a new address no earlier than the cycle in which it returns its previous word. With one bank, the next address goes out in the same cycle as the previous word's data phase.
- R5: Each cycle carries at most one address and at most one data word. An address and a data word may share a cycle. When several banks are ready at once, the lowest word offset is returned first.
- R6: The word on mem_rdata during a data phase is stored at the offset given by the low three bits of mem_data_addr. In fill_block, word i occupies bits [32*i+31 : 32*i].
- R7: fill_done is high for exactly one cycle, and the newly filled block appears on fill_block in that cycle. fill_done becomes visible 29, 46 or 169 clock edges after the accepting edge, for 8, 4 or 1 banks.
- R8: fill_block changes only in a cycle in which fill_done is high. During a fill it keeps the previous block.
- R9: A request that arrives while a fill is running is ignored. It produces no extra addresses and does not move the completion time.
- R10: A request presented in the cycle in which fill_done is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req | input | 1 | Refill request, sampled only while idle |
| fill_addr | input | ADDR_W | Word address inside the block to fill |
| mem_addr_vld | output | 1 | Address lane carries a word address this cycle |
| mem_addr | output | ADDR_W | Word address sent to a bank |
| mem_data_vld | output | 1 | Data phase: the memory drives a word this cycle |
| mem_data_addr | output | ADDR_W | Word address whose data the memory must drive |
| mem_rdata | input | DATA_W | Word returned by the memory during a data phase |
| fill_done | output | 1 | One-cycle strobe: fill_block holds the complete new block |
| fill_block | output | BLOCK_WORDS*DATA_W | Completed block, word i at bits [DATA_W*i +: DATA_W] |

## Verification
The assertions take three things for granted. The memory answers every data phase in the same cycle with the word for mem_data_addr. fill_addr matters only at the accepting edge. Reset is held for at least one edge before any request.

The stimulus meets these conditions as follows. The memory model is a pure function of the shown address and is evaluated continuously. Requests are one-cycle pulses driven at the falling edge. Three sequencers, with 8, 4 and 1 banks, receive the same request stream, so the same pulse lands at different points of each fill. That covers a request inside a running fill, a request in the completion cycle, and a request with a misaligned address.

// File: rtl/blkfill_pkg.sv
package blkfill_pkg;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_st_e;

  localparam int unsigned BANK_ACCESS_DEFAULT = 20;

endpackage

// File: rtl/blkfill_bank.sv
// One memory bank's occupancy: loaded with a word offset when its address
// goes out, counts the fixed access time, then waits for a data grant.
module blkfill_bank #(
  parameter int unsigned ACCESS_CYC = 20,
  parameter int unsigned OFF_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] load_word,
  input  logic             grant,
  output logic             busy,
  output logic             ready,
  output logic [OFF_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(ACCESS_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      word  <= '0;
    end else if (load) begin
      // a load may coincide with the grant of the previous word
      busy  <= 1'b1;
      cnt_q <= CNT_W'(ACCESS_CYC);
      word  <= load_word;
    end else if (grant) begin
      busy  <= 1'b0;
    end else if (busy && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = busy && (cnt_q == '0);

endmodule

// File: rtl/blkfill_ret_arb.sv
// Picks the ready bank holding the lowest word offset for the data lane.
module blkfill_ret_arb #(
  parameter int unsigned NB    = 8,
  parameter int unsigned OFF_W = 3
) (
  input  logic [NB-1:0]       rdy,
  input  logic [NB*OFF_W-1:0] words,
  output logic [NB-1:0]       gnt,
  output logic                gvld,
  output logic [OFF_W-1:0]    gword
);
  always_comb begin
    gnt   = '0;
    gvld  = 1'b0;
    gword = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (rdy[b] && (!gvld || words[b*OFF_W +: OFF_W] < gword)) begin
        gnt    = '0;
        gnt[b] = 1'b1;
        gvld   = 1'b1;
        gword  = words[b*OFF_W +: OFF_W];
      end
    end
  end

endmodule

// File: rtl/blkfill_buf.sv
// Staging buffer written one word at a time, plus the delivered block,
// which is loaded only when the final word arrives.
module blkfill_buf #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [OFF_W-1:0]        wr_off,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    commit,
  output logic [WORDS*DATA_W-1:0] block_out
);
  logic [DATA_W-1:0] stage_q [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) stage_q[wr_off] <= wr_data;
  end

  for (genvar i = 0; i < int'(WORDS); i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        block_out[i*DATA_W +: DATA_W] <= '0;
      end else if (commit) begin
        block_out[i*DATA_W +: DATA_W] <= (wr_off == OFF_W'(i)) ? wr_data : stage_q[i];
      end
    end
  end

endmodule

// File: rtl/blkfill_seq.sv
module blkfill_seq
  import blkfill_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned ACCESS_CYC  = BANK_ACCESS_DEFAULT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fill_req,
  input  logic [ADDR_W-1:0]             fill_addr,
  output logic                          mem_addr_vld,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic                          mem_data_vld,
  output logic [ADDR_W-1:0]             mem_data_addr,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          fill_done,
  output logic [BLOCK_WORDS*DATA_W-1:0] fill_block
);
  localparam int unsigned OFF_W = $clog2(BLOCK_WORDS);
  localparam int unsigned IDX_W = OFF_W + 1;
  localparam int unsigned TAG_W = ADDR_W - OFF_W;

  fill_st_e                 st_q;
  logic [TAG_W-1:0]         tag_q;
  logic [IDX_W-1:0]         issue_q;
  logic [IDX_W-1:0]         got_q;

  logic [NUM_BANKS-1:0]       bank_busy, bank_rdy, bank_free, bank_load, want, grant;
  logic [NUM_BANKS*OFF_W-1:0] bank_word;
  logic                       gvld;
  logic [OFF_W-1:0]           gword;

  logic             accept, issue_ok, run_issue, issue_go, last_cap;
  logic [OFF_W-1:0] issue_word;
  logic [TAG_W-1:0] issue_tag;

  assign accept     = (st_q == FILL_IDLE) && fill_req;
  assign issue_word = accept ? '0 : issue_q[OFF_W-1:0];
  assign issue_tag  = accept ? fill_addr[ADDR_W-1:OFF_W] : tag_q;

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    assign want[b]      = ((int'(issue_word) % int'(NUM_BANKS)) == b);
    assign bank_free[b] = !bank_busy[b] || grant[b];
    assign bank_load[b] = issue_go && want[b];

    blkfill_bank #(
      .ACCESS_CYC(ACCESS_CYC),
      .OFF_W     (OFF_W)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .load     (bank_load[b]),
      .load_word(issue_word),
      .grant    (grant[b]),
      .busy     (bank_busy[b]),
      .ready    (bank_rdy[b]),
      .word     (bank_word[b*OFF_W +: OFF_W])
    );
  end

  blkfill_ret_arb #(
    .NB   (NUM_BANKS),
    .OFF_W(OFF_W)
  ) u_arb (
    .rdy  (bank_rdy),
    .words(bank_word),
    .gnt  (grant),
    .gvld (gvld),
    .gword(gword)
  );

  assign issue_ok  = |(want & bank_free);
  assign run_issue = (st_q == FILL_RUN) && (issue_q < IDX_W'(BLOCK_WORDS)) && issue_ok;
  assign issue_go  = accept || run_issue;
  assign last_cap  = mem_data_vld && (got_q == IDX_W'(BLOCK_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= FILL_IDLE;
      tag_q         <= '0;
      issue_q       <= '0;
      got_q         <= '0;
      mem_addr_vld  <= 1'b0;
      mem_addr      <= '0;
      mem_data_vld  <= 1'b0;
      mem_data_addr <= '0;
      fill_done     <= 1'b0;
    end else begin
      mem_addr_vld <= issue_go;
      if (issue_go) mem_addr <= {issue_tag, issue_word};
      mem_data_vld <= gvld;
      if (gvld) mem_data_addr <= {tag_q, gword};
      fill_done <= last_cap;
      if (accept) begin
        st_q    <= FILL_RUN;
        tag_q   <= fill_addr[ADDR_W-1:OFF_W];
        issue_q <= IDX_W'(1);
        got_q   <= '0;
      end else begin
        if (run_issue)    issue_q <= issue_q + 1'b1;
        if (mem_data_vld) got_q   <= got_q + 1'b1;
        if (last_cap)     st_q    <= FILL_IDLE;
      end
    end
  end

  blkfill_buf #(
    .WORDS (BLOCK_WORDS),
    .DATA_W(DATA_W),
    .OFF_W (OFF_W)
  ) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mem_data_vld),
    .wr_off   (mem_data_addr[OFF_W-1:0]),
    .wr_data  (mem_rdata),
    .commit   (last_cap),
    .block_out(fill_block)
  );

endmodule

// File: rtl/blkfill_seq_chk.sv
module blkfill_seq_chk
  import blkfill_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned DATA_W      = 32
) (
  input logic                          clk,
  input logic                          rst,
  input fill_st_e                      st_q,
  input logic                          mem_addr_vld,
  input logic                          mem_data_vld,
  input logic                          fill_done,
  input logic [BLOCK_WORDS*DATA_W-1:0] fill_block,
  input logic [NUM_BANKS-1:0]          grant,
  input logic [NUM_BANKS-1:0]          bank_load,
  input logic [NUM_BANKS-1:0]          bank_busy
);

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == FILL_IDLE) |-> (!mem_addr_vld && !mem_data_vld)); // R1

  AST_BANK_FREE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(|(bank_load & bank_busy & ~grant))); // R4

  AST_ONE_DATA_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> !fill_done); // R7

  AST_DONE_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> $past(mem_data_vld)); // R7

  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    !fill_done |-> $stable(fill_block)); // R8

endmodule

bind blkfill_seq blkfill_seq_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .BLOCK_WORDS(BLOCK_WORDS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_q        (st_q),
  .mem_addr_vld(mem_addr_vld),
  .mem_data_vld(mem_data_vld),
  .fill_done   (fill_done),
  .fill_block  (fill_block),
  .grant       (grant),
  .bank_load   (bank_load),
  .bank_busy   (bank_busy)
);

// File: tb/blkfill_seq_test.sv
module blkfill_seq_test;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int BW    = 8;
  localparam int ACC   = 20;
  localparam int LANES = 3;
  localparam int NB [LANES] = '{8, 4, 1};

  typedef struct {
    int            t;
    logic [AW-1:0] a;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [AW-1:0] raddr = '0;

  logic          av  [LANES];
  logic          dv  [LANES];
  logic          dn  [LANES];
  logic [AW-1:0] aa  [LANES];
  logic [AW-1:0] da  [LANES];
  logic [DW-1:0] rd  [LANES];
  logic [BW*DW-1:0] blk  [LANES];
  logic [BW*DW-1:0] held [LANES];

  ev_t aq  [LANES][$];
  ev_t dq  [LANES][$];
  ev_t fq  [LANES][$];
  int  free_at [LANES];

  int tnow   = 0;
  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) tnow <= tnow + 1;

  function automatic logic [DW-1:0] memword(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic logic [BW*DW-1:0] expblock(input logic [AW-1:0] base);
    logic [BW*DW-1:0] r;
    for (int i = 0; i < BW; i++) r[i*DW +: DW] = memword(base | AW'(i));
    return r;
  endfunction

  blkfill_seq #(.NUM_BANKS(8)) uut (
    .clk(clk), .rst(rst), .fill_req(req), .fill_addr(raddr),
    .mem_addr_vld(av[0]), .mem_addr(aa[0]), .mem_data_vld(dv[0]),
    .mem_data_addr(da[0]), .mem_rdata(rd[0]), .fill_done(dn[0]), .fill_block(blk[0]));

  blkfill_seq #(.NUM_BANKS(4)) uut_b4 (
    .clk(clk), .rst(rst), .fill_req(req), .fill_addr(raddr),
    .mem_addr_vld(av[1]), .mem_addr(aa[1]), .mem_data_vld(dv[1]),
    .mem_data_addr(da[1]), .mem_rdata(rd[1]), .fill_done(dn[1]), .fill_block(blk[1]));

  blkfill_seq #(.NUM_BANKS(1)) uut_b1 (
    .clk(clk), .rst(rst), .fill_req(req), .fill_addr(raddr),
    .mem_addr_vld(av[2]), .mem_addr(aa[2]), .mem_data_vld(dv[2]),
    .mem_data_addr(da[2]), .mem_rdata(rd[2]), .fill_done(dn[2]), .fill_block(blk[2]));

  for (genvar l = 0; l < LANES; l++) begin : g_mem
    assign rd[l] = memword(da[l]);
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin
      free_at[l] = 0;
      held[l]    = '0;
    end
  end

  // Driver: one-cycle request pulse; pushes the expected schedule of every
  // idle lane (R2, R3, R4, R7). Busy lanes get nothing (R9).
  task automatic send_req(input logic [AW-1:0] ad);
    int a [BW];
    logic [AW-1:0] base;
    @(negedge clk);
    req   = 1'b1;
    raddr = ad;
    base  = ad & ~AW'(BW - 1);
    for (int l = 0; l < LANES; l++) begin
      if (tnow >= free_at[l]) begin
        for (int w = 0; w < BW; w++) begin
          if (w < NB[l]) a[w] = w + 1;
          else begin
            a[w] = a[w-1] + 1;
            if (a[w-NB[l]] + ACC + 1 > a[w]) a[w] = a[w-NB[l]] + ACC + 1;
          end
          aq[l].push_back('{tnow + a[w], base | AW'(w)});
          dq[l].push_back('{tnow + a[w] + ACC + 1, base | AW'(w)});
        end
        fq[l].push_back('{tnow + a[BW-1] + ACC + 2, base});
        free_at[l] = tnow + a[BW-1] + ACC + 2;
      end
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  // Monitor: scoreboard comparison at the falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      for (int l = 0; l < LANES; l++) begin
        if (aq[l].size() > 0 && aq[l][0].t == tnow) begin
          n_run++;
          if (!av[l] || aa[l] !== aq[l][0].a) begin
            n_fail++;
            $display("FAIL R2 R4 R5 banks=%0d t=%0d actual vld=%0b addr=%h expected addr=%h",
                     NB[l], tnow, av[l], aa[l], aq[l][0].a);
          end
          aq[l].delete(0);
        end else if (av[l]) begin
          n_run++; n_fail++;
          $display("FAIL R9 banks=%0d t=%0d actual unexpected addr=%h expected no address",
                   NB[l], tnow, aa[l]);
        end
        if (dq[l].size() > 0 && dq[l][0].t == tnow) begin
          n_run++;
          if (!dv[l] || da[l] !== dq[l][0].a) begin
            n_fail++;
            $display("FAIL R3 banks=%0d t=%0d actual vld=%0b addr=%h expected addr=%h",
                     NB[l], tnow, dv[l], da[l], dq[l][0].a);
          end
          dq[l].delete(0);
        end else if (dv[l]) begin
          n_run++; n_fail++;
          $display("FAIL R3 banks=%0d t=%0d actual unexpected data addr=%h expected none",
                   NB[l], tnow, da[l]);
        end
        if (fq[l].size() > 0 && fq[l][0].t == tnow) begin
          n_run++;
          held[l] = expblock(fq[l][0].a);
          if (!dn[l] || blk[l] !== held[l]) begin
            n_fail++;
            $display("FAIL R6 R7 banks=%0d t=%0d actual done=%0b block=%h expected block=%h",
                     NB[l], tnow, dn[l], blk[l], held[l]);
          end
          fq[l].delete(0);
        end else begin
          n_run++;
          if (dn[l]) begin
            n_fail++;
            $display("FAIL R7 banks=%0d t=%0d actual done=1 expected done=0", NB[l], tnow);
          end else if (blk[l] !== held[l]) begin
            n_fail++;
            $display("FAIL R8 banks=%0d t=%0d actual block=%h expected block=%h",
                     NB[l], tnow, blk[l], held[l]);
          end
        end
      end
    end
  end

  task automatic wait_idle();
    int last;
    last = 0;
    for (int l = 0; l < LANES; l++) if (free_at[l] > last) last = free_at[l];
    while (tnow < last + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of every lane
    for (int l = 0; l < LANES; l++) begin
      n_run++;
      if (av[l] || dv[l] || dn[l] || blk[l] !== '0) begin
        n_fail++;
        $display("FAIL R1 banks=%0d actual av=%0b dv=%0b done=%0b block=%h expected all zero",
                 NB[l], av[l], dv[l], dn[l], blk[l]);
      end
    end

    // R2: misaligned request address; the fill covers the aligned block
    send_req(16'h1234);
    repeat (10) @(negedge clk);
    // R9: request while every lane is busy
    send_req(16'h4440);

    // R10: request presented in the completion cycle of the 8-bank lane
    while (tnow < free_at[0] - 1) @(negedge clk);
    send_req(16'h7F08);
    n_run++;
    if (!av[0] || aa[0] !== 16'h7F08) begin
      n_fail++;
      $display("FAIL R10 t=%0d actual vld=%0b addr=%h expected addr=7f08", tnow, av[0], aa[0]);
    end

    wait_idle();
    send_req(16'hBEEF);
    repeat (30) @(negedge clk);
    // R9 again: mid-fill for the 4-bank and 1-bank lanes
    send_req(16'h0011);
    wait_idle();
    repeat (4) @(negedge clk);

    // R7: every expected completion was observed
    for (int l = 0; l < LANES; l++) begin
      n_run++;
      if (aq[l].size() != 0 || dq[l].size() != 0 || fq[l].size() != 0) begin
        n_fail++;
        $display("FAIL R7 banks=%0d actual pending=%0d expected pending=0",
                 NB[l], aq[l].size() + dq[l].size() + fq[l].size());
      end
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

endmodule